// File: doc/BRIEF.md
# Four-Phase Memory Clock Sequencer

This block produces the four non-overlapping timing strobes that a four-phase dynamic memory needs for each access. A fast input clock drives a synchronous modulo-12 counter; a decoder turns counter states into four phase strobes and a cycle-start flag, and both are registered before they leave the block. At the nominal 25 MHz input clock, one count is 40 ns, one full sequence is 480 ns, and each phase strobe is 80 ns wide.

Within a 12-count sequence, the phases sit at counts 0-1, 3-4, 6-7 and 9-10. Each phase is followed by one idle count, so no two strobes are ever high together. A synchronous reset and an enable input control the sequence. While enable is low the counter is parked and every output is low. When enable returns, a fresh sequence starts at count 0.

Top module: `quad_phase_seq`

## Requirements
- R1: While `en` is high and `rst` is low, the internal count advances by one on every rising clock edge, so the output pattern repeats exactly every 12 clock cycles.
- R2: After count 11 the count returns to 0, and the pattern of count 0 follows the pattern of count 11 directly.
- R3: Phase k (bit k of `phase_o`, k = 0..3) is high exactly for counts 3k and 3k+1. At most one bit of `phase_o` is high in any cycle.
- R4: Every phase strobe is two clock cycles wide and is followed by one cycle in which all of `phase_o` is low (counts 2, 5, 8 and 11).
- R5: `start_o` is high for one cycle per sequence, in the cycle that shows count 0, together with the first cycle of phase 0.
- R6: A cycle whose edge sees `en` low drives all of `phase_o` and `start_o` low and parks the count at 0. The first enabled edge after that shows the count-0 pattern.
- R7: A rising edge with `rst` high clears the count to 0 and drives all outputs low, whatever `en` is. The first enabled edge after reset shows the count-0 pattern.
- R8: The outputs are registers loaded from the count held before the edge. The edge that first sees `en` high after reset or disable therefore presents the count-0 pattern, with one cycle of latency from count to strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock; one count per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low parks the count at 0 and blanks the outputs |
| phase_o | output | 4 | Registered phase strobes; bit k is phase k |
| start_o | output | 1 | Registered one-cycle flag marking count 0 of each sequence |

## Verification
The sequencer is first run freely across several whole sequences. This shows whether the strobe positions, the two-cycle widths, the idle gaps and the wrap from 11 to 0 line up with a 12-cycle period. Enable is then dropped in the middle of a sequence and raised again, which separates a design that resumes from count 0 from one that resumes where it stopped. A reset pulse in the middle of a run, with enable held high, shows whether reset takes priority over enable and whether the first strobe after release appears with one cycle of latency.

// File: rtl/qps_pkg.sv
package qps_pkg;

  // True when count c falls inside the active window of phase k.
  function automatic logic phase_hit(int c, int k, int width, int gap);
    int first;
    first = k * (width + gap);
    return (c >= first) && (c < first + width);
  endfunction

  // Length of the stride that separates two successive phase starts.
  function automatic int phase_stride(int width, int gap);
    return width + gap;
  endfunction

endpackage

// File: rtl/qps_counter.sv
module qps_counter #(
  parameter int DIV = 12,
  parameter int CW  = $clog2(DIV)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic [CW-1:0] cnt,
  output logic          cnt_wrap
);

  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  assign cnt_wrap = en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
    end else if (cnt_wrap) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/qps_decode.sv
module qps_decode #(
  parameter int NPH   = 4,
  parameter int PH_W  = 2,
  parameter int PH_G  = 1,
  parameter int CW    = 4
) (
  input  logic [CW-1:0]  cnt,
  output logic [NPH-1:0] dec_phase,
  output logic           dec_start
);

  import qps_pkg::*;

  for (genvar k = 0; k < NPH; k++) begin : g_phase
    assign dec_phase[k] = phase_hit(int'(cnt), k, PH_W, PH_G);
  end

  assign dec_start = (cnt == '0);

endmodule

// File: rtl/qps_outreg.sv
module qps_outreg #(
  parameter int NPH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic [NPH-1:0] dec_phase,
  input  logic           dec_start,
  output logic [NPH-1:0] phase_q,
  output logic           start_q
);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      phase_q <= '0;
      start_q <= 1'b0;
    end else begin
      phase_q <= dec_phase;
      start_q <= dec_start;
    end
  end

endmodule

// File: rtl/quad_phase_seq.sv
module quad_phase_seq #(
  parameter int DIV  = 12,
  parameter int NPH  = 4,
  parameter int PH_W = 2,
  parameter int PH_G = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  output logic [NPH-1:0] phase_o,
  output logic           start_o
);

  localparam int CW = $clog2(DIV);

  logic [CW-1:0]  cnt;
  logic           cnt_wrap;
  logic [NPH-1:0] dec_phase;
  logic           dec_start;

  qps_counter #(.DIV(DIV), .CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .en(en), .cnt(cnt), .cnt_wrap(cnt_wrap)
  );

  qps_decode #(.NPH(NPH), .PH_W(PH_W), .PH_G(PH_G), .CW(CW)) u_dec (
    .cnt(cnt), .dec_phase(dec_phase), .dec_start(dec_start)
  );

  qps_outreg #(.NPH(NPH)) u_out (
    .clk(clk), .rst(rst), .en(en),
    .dec_phase(dec_phase), .dec_start(dec_start),
    .phase_q(phase_o), .start_q(start_o)
  );

endmodule

// File: rtl/qps_checker.sv
module qps_checker #(
  parameter int DIV = 12,
  parameter int NPH = 4,
  parameter int CW  = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           en,
  input logic [CW-1:0]  cnt,
  input logic           cnt_wrap,
  input logic [NPH-1:0] phase_o,
  input logic           start_o
);

  // R2: the last count is followed by count 0
  a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    cnt_wrap |=> (cnt == '0));

  // R1: enabled count advances by one below the last count
  a_r1_step: assert property (@(posedge clk) disable iff (rst)
    (en && !cnt_wrap) |=> (cnt == $past(cnt) + 1'b1));

  // R3: never two strobes at once
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (rst)
    $onehot0(phase_o));

  // R5: start flag only with the first cycle of phase 0
  a_r5_start_with_p0: assert property (@(posedge clk) disable iff (rst)
    start_o |-> (phase_o[0] && $countones(phase_o) == 1));

  // R6: disabled edge blanks outputs and parks the count
  a_r6_disable_blank: assert property (@(posedge clk) disable iff (rst)
    !en |=> (phase_o == '0 && !start_o && cnt == '0));

  // R7: reset clears state on the next cycle regardless of enable
  a_r7_reset_clear: assert property (@(posedge clk)
    rst |=> (phase_o == '0 && !start_o && cnt == '0));

  for (genvar k = 0; k < NPH; k++) begin : g_ph
    // R4: a strobe that rises stays high for its second count
    a_r4_two_wide: assert property (@(posedge clk) disable iff (rst)
      ($rose(phase_o[k]) && en) |=> phase_o[k]);
    // R4: a strobe never lasts a third count
    a_r4_no_third: assert property (@(posedge clk) disable iff (rst)
      (phase_o[k] && $past(phase_o[k])) |=> !phase_o[k]);
    // R4: the cycle after a strobe ends is fully idle
    a_r4_idle_gap: assert property (@(posedge clk) disable iff (rst)
      $fell(phase_o[k]) |-> (phase_o == '0));
  end

endmodule

bind quad_phase_seq qps_checker #(.DIV(DIV), .NPH(NPH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .en(en), .cnt(cnt), .cnt_wrap(cnt_wrap),
  .phase_o(phase_o), .start_o(start_o)
);

// File: tb/tb_quad_phase_seq.sv
module tb_quad_phase_seq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [3:0] phase_o;
  logic       start_o;

  int checks = 0;
  int errors = 0;
  int idx    = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [4:0] v;
    string      tag;
  } item_t;

  item_t sb[$];

  always #4 clk = ~clk;

  quad_phase_seq dut (
    .clk(clk), .rst(rst), .en(en), .phase_o(phase_o), .start_o(start_o)
  );

  // Expected {start, phase[3:0]} for a count, listed by hand.
  function automatic logic [4:0] pattern(int c);
    case (c)
      0:       return 5'b1_0001;
      1:       return 5'b0_0001;
      3, 4:    return 5'b0_0010;
      6, 7:    return 5'b0_0100;
      9, 10:   return 5'b0_1000;
      default: return 5'b0_0000;
    endcase
  endfunction

  function automatic string auto_tag(int c);
    if (c == 0) return "R5";
    if (c == 11) return "R2";
    if (c == 2 || c == 5 || c == 8) return "R4";
    return "R3";
  endfunction

  task automatic drive(int n, logic r, logic e, string tag);
    for (int i = 0; i < n; i++) begin
      item_t it;
      @(negedge clk);
      rst = r;
      en  = e;
      if (r || !e) begin
        it.v = 5'b0;
        it.tag = (tag == "") ? "R6" : tag;
        idx = 0;
      end else begin
        it.v = pattern(idx);
        it.tag = (tag == "") ? auto_tag(idx) : tag;
        idx = (idx + 1) % 12;
      end
      sb.push_back(it);
    end
  endtask

  // Monitor: compare each produced cycle against the scoreboard.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if ({start_o, phase_o} !== it.v) begin
          errors++;
          $display("FAIL %s actual=%b expected=%b", it.tag, {start_o, phase_o}, it.v);
        end
      end
    end
  end

  initial begin
    drive(3, 1'b1, 1'b1, "R7");      // reset state, enable ignored
    drive(1, 1'b0, 1'b1, "R8");      // first enabled edge shows count 0
    drive(23, 1'b0, 1'b1, "");       // rest of two sequences
    drive(24, 1'b0, 1'b1, "R1");     // 12-cycle periodicity
    drive(5, 1'b0, 1'b1, "");        // stop inside phase 1
    drive(4, 1'b0, 1'b0, "R6");      // disabled: all low
    drive(1, 1'b0, 1'b1, "R6");      // resume at count 0
    drive(13, 1'b0, 1'b1, "");
    drive(4, 1'b0, 1'b1, "");
    drive(1, 1'b1, 1'b1, "R7");      // reset mid-run wins over enable
    drive(1, 1'b0, 1'b1, "R7");      // restart at count 0
    drive(14, 1'b0, 1'b1, "");
    @(posedge clk);
    #4;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule